// File: doc/BRIEF.md
# Virtual Subunit Fault Regrouping Mapper

This block owns the table that gathers the submodules of a three-phase modular multilevel converter into virtual three-level subunits. Each subunit has six slots, two per phase, and all six submodules sit on the same arm. There are `N_SU` subunits. The first half belong to the upper arm and the second half to the lower arm. The table entries are free submodule indices, so a subunit's members do not have to be neighbours.

When a fault-change strobe arrives, the block captures the per-submodule fault flags and rebuilds the table from the identity grouping. It then scans the subunits in order, one step per clock. A subunit that holds two or more faulty submodules hands each extra fault to a fault-free subunit on the same arm. The two subunits swap the occupants of the same slot, so every submodule keeps its phase. When the scan ends, each subunit holds at most one fault and is reported as type none, u, v or w. The modulators read the resulting table and the type codes.

If an arm has more faulty submodules than it has subunits, the rewrite cannot succeed. The block then flags this and keeps its previous outputs.

Top module: `vsu_fault_mapper`

## Requirements
- R1: After reset, the table is the identity grouping, every type code is 0, and `busy_o`, `done_o` and `unrecov_o` are low.
- R2: Identity grouping, with H = N_SU/2:
  - Subunit i is on arm a = i/H, with local index l = i%H.
  - Its slot j (0..5) holds submodule (a*3 + j/2)*N_SU + 2*l + j%2.
  - The phase of a submodule s is (s/N_SU)%3, with u=0, v=1 and w=2. Its arm is s/(3*N_SU).
  - Every rewrite starts from this grouping, so an update with no faults restores it.
- R3: After a successful rewrite, no subunit holds more than one faulty submodule.
- R4: After a rewrite, the table is a permutation of all submodules. Slot j of subunit i holds a submodule of phase j/2 on the arm of subunit i.
- R5: The type code of subunit i is `ftype_o[2i+1:2i]`. It is 0 when the subunit has no faulty submodule. Otherwise it is 1, 2 or 3 for a fault in phase u, v or w.
- R6: Subunits are scanned in ascending order. While the scanned subunit holds two or more faults, its second-lowest faulty slot swaps occupant with the same slot of the lowest-index fault-free subunit on its arm.
- R7: If some arm has more than N_SU/2 faulty submodules:
  - `unrecov_o` is set and the table and type codes stay unchanged.
  - Otherwise `unrecov_o` is cleared.
  - The flag holds until the next rewrite ends.
- R8: `done_o` is a one-cycle pulse. For a recoverable pattern it comes N_SU + S clock edges after the capturing edge. S is the total fault count minus the number of identity subunits that contain a fault. `busy_o` is high from the capturing edge until `done_o`.
- R9: A strobe while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | Fault-change strobe; captures `fault_i` when idle |
| fault_i | input | 6*N_SU | Per-submodule fault flags |
| map_o | output | 6*N_SU*IDX_W | Slot j of subunit i at bits (i*6+j)*IDX_W upward |
| ftype_o | output | 2*N_SU | Per-subunit fault type codes |
| busy_o | output | 1 | Rewrite in progress |
| done_o | output | 1 | One-cycle completion pulse |
| unrecov_o | output | 1 | Last rewrite could not isolate all faults |

## Verification
Some internal faults show up at `done_o` as a table that is not a permutation or that puts a submodule in a slot of the wrong phase. Others leave a subunit with two faults or with a type code that does not match its faulty member. A wrong donor choice changes which slots are swapped, so directed patterns compare exact entries. Counter or state faults move the `done_o` pulse away from N_SU + S edges, and this is detected in the very first rewrite that follows.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  localparam int SLOTS = 6;

  typedef enum logic [1:0] {
    FT_NONE = 2'd0,
    FT_U    = 2'd1,
    FT_V    = 2'd2,
    FT_W    = 2'd3
  } ftype_e;

  function automatic ftype_e phase_to_type(input int unsigned p);
    case (p)
      0:       return FT_U;
      1:       return FT_V;
      default: return FT_W;
    endcase
  endfunction

  // R2: identity grouping
  function automatic int unsigned ident_idx(input int unsigned n_su, input int unsigned su,
                                            input int unsigned slot);
    int unsigned half, a, l, p;
    half = n_su / 2;
    a    = su / half;
    l    = su % half;
    p    = slot / 2;
    return (a * 3 + p) * n_su + 2 * l + (slot % 2);
  endfunction
endpackage

// File: rtl/vsu_slot_scan.sv
module vsu_slot_scan
  import vsu_pkg::*;
#(
  parameter int N_SM  = 24,
  parameter int IDX_W = 5
) (
  input  logic [N_SM-1:0]        fault_i,
  input  logic [SLOTS*IDX_W-1:0] idx_i,
  output logic                   any_o,
  output logic                   multi_o,
  output logic [2:0]             second_o,
  output logic [1:0]             type_o
);
  logic [2:0] cnt;
  logic       hit;

  always_comb begin
    cnt      = '0;
    second_o = '0;
    type_o   = FT_NONE;
    for (int j = 0; j < SLOTS; j++) begin
      hit = fault_i[idx_i[j*IDX_W +: IDX_W]];
      if (hit) begin
        if (cnt == 3'd1) second_o = 3'(j);
        cnt    = cnt + 3'd1;
        type_o = phase_to_type(j / 2);
      end
    end
    any_o   = (cnt != 3'd0);
    multi_o = (cnt > 3'd1);
  end
endmodule

// File: rtl/vsu_donor_pick.sv
module vsu_donor_pick #(
  parameter int N_SU = 4,
  localparam int SU_W = (N_SU > 1) ? $clog2(N_SU) : 1,
  localparam int HALF = N_SU / 2
) (
  input  logic [N_SU-1:0] healthy_i,
  input  logic            arm_i,
  output logic            found_o,
  output logic [SU_W-1:0] idx_o
);
  // R6: lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N_SU - 1; k >= 0; k--) begin
      if (healthy_i[k] && ((k >= HALF) == arm_i)) begin
        found_o = 1'b1;
        idx_o   = SU_W'(k);
      end
    end
  end
endmodule

// File: rtl/vsu_fault_mapper.sv
module vsu_fault_mapper
  import vsu_pkg::*;
#(
  parameter int N_SU = 4,
  localparam int N_SM  = SLOTS * N_SU,
  localparam int IDX_W = $clog2(N_SM),
  localparam int SU_W  = (N_SU > 1) ? $clog2(N_SU) : 1,
  localparam int HALF  = N_SU / 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         update_i,
  input  logic [N_SM-1:0]              fault_i,
  output logic [N_SU*SLOTS*IDX_W-1:0]  map_o,
  output logic [2*N_SU-1:0]            ftype_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         unrecov_o
);
  typedef enum logic {ST_IDLE, ST_SCAN} state_e;

  state_e            state_q;
  logic [SU_W-1:0]   ptr_q;
  logic [N_SM-1:0]   fault_q;
  logic [IDX_W-1:0]  work_q [N_SU][SLOTS];
  logic [IDX_W-1:0]  map_q  [N_SU][SLOTS];
  logic [1:0]        ftype_q [N_SU];
  logic              done_q, unrecov_q;

  logic              any_w    [N_SU];
  logic              multi_w  [N_SU];
  logic [2:0]        second_w [N_SU];
  logic [1:0]        type_w   [N_SU];
  logic [N_SU-1:0]   healthy_w;

  logic              donor_found;
  logic [SU_W-1:0]   donor_idx;
  logic              cur_arm;
  logic [2:0]        cur_sec;

  for (genvar i = 0; i < N_SU; i++) begin : g_su
    logic [SLOTS*IDX_W-1:0] idx_flat;
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      assign idx_flat[j*IDX_W +: IDX_W]             = work_q[i][j];
      assign map_o[(i*SLOTS+j)*IDX_W +: IDX_W]      = map_q[i][j];
    end
    vsu_slot_scan #(.N_SM(N_SM), .IDX_W(IDX_W)) u_scan (
      .fault_i  (fault_q),
      .idx_i    (idx_flat),
      .any_o    (any_w[i]),
      .multi_o  (multi_w[i]),
      .second_o (second_w[i]),
      .type_o   (type_w[i])
    );
    assign healthy_w[i]       = !any_w[i];
    assign ftype_o[2*i +: 2]  = ftype_q[i];
  end

  assign cur_arm = (int'(ptr_q) >= HALF);
  assign cur_sec = second_w[ptr_q];

  vsu_donor_pick #(.N_SU(N_SU)) u_donor (
    .healthy_i (healthy_w),
    .arm_i     (cur_arm),
    .found_o   (donor_found),
    .idx_o     (donor_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      fault_q   <= '0;
      done_q    <= 1'b0;
      unrecov_q <= 1'b0;
      for (int i = 0; i < N_SU; i++) begin
        ftype_q[i] <= FT_NONE;
        for (int j = 0; j < SLOTS; j++) begin
          work_q[i][j] <= IDX_W'(ident_idx(N_SU, i, j));
          map_q[i][j]  <= IDX_W'(ident_idx(N_SU, i, j));
        end
      end
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (update_i) begin  // R9: only accepted here
            fault_q <= fault_i;
            ptr_q   <= '0;
            state_q <= ST_SCAN;
            for (int i = 0; i < N_SU; i++)
              for (int j = 0; j < SLOTS; j++)
                work_q[i][j] <= IDX_W'(ident_idx(N_SU, i, j));
          end
        end
        default: begin
          if (multi_w[ptr_q]) begin
            if (donor_found) begin  // R6: same-slot swap keeps phase and arm
              work_q[ptr_q][cur_sec]     <= work_q[donor_idx][cur_sec];
              work_q[donor_idx][cur_sec] <= work_q[ptr_q][cur_sec];
            end else begin          // R7
              unrecov_q <= 1'b1;
              done_q    <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end else if (ptr_q == SU_W'(N_SU - 1)) begin
            for (int i = 0; i < N_SU; i++) begin
              ftype_q[i] <= type_w[i];
              for (int j = 0; j < SLOTS; j++) map_q[i][j] <= work_q[i][j];
            end
            unrecov_q <= 1'b0;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o    = (state_q == ST_SCAN);
  assign done_o    = done_q;
  assign unrecov_o = unrecov_q;
endmodule

// File: rtl/vsu_fault_mapper_chk.sv
module vsu_fault_mapper_chk #(
  parameter int N_SU = 4,
  localparam int N_SM  = 6 * N_SU,
  localparam int IDX_W = $clog2(N_SM)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        update_i,
  input logic [N_SM-1:0]             fault_i,
  input logic [N_SU*6*IDX_W-1:0]     map_o,
  input logic [2*N_SU-1:0]           ftype_o,
  input logic                        busy_o,
  input logic                        done_o,
  input logic                        unrecov_o
);
  logic [N_SM-1:0] cap_q;
  logic            single_ok, type_ok;
  logic [2:0]      c;
  logic [1:0]      t;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cap_q <= '0;
    else if (update_i && !busy_o) cap_q <= fault_i;
  end

  always_comb begin
    single_ok = 1'b1;
    type_ok   = 1'b1;
    for (int i = 0; i < N_SU; i++) begin
      c = '0;
      t = '0;
      for (int j = 0; j < 6; j++) begin
        if (cap_q[map_o[(i*6+j)*IDX_W +: IDX_W]]) begin
          c = c + 3'd1;
          t = 2'(j / 2 + 1);
        end
      end
      if (c > 3'd1) single_ok = 1'b0;
      if (ftype_o[2*i +: 2] != t) type_ok = 1'b0;
    end
  end

  AST_DONE_PULSE:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                     done_o |=> !done_o);                                      // R8
  AST_DONE_IDLE:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     done_o |-> !busy_o);                                      // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (update_i && !busy_o) |=> busy_o);                        // R8
  AST_MAP_HOLD:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                     !$stable(map_o) |-> (done_o && !unrecov_o));              // R7
  AST_TYPE_HOLD:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     !$stable(ftype_o) |-> (done_o && !unrecov_o));            // R7
  AST_ONE_FAULT:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (done_o && !unrecov_o) |-> single_ok);                    // R3
  AST_TYPE_MATCH:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (done_o && !unrecov_o) |-> type_ok);                      // R5
endmodule

bind vsu_fault_mapper vsu_fault_mapper_chk #(.N_SU(N_SU)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .update_i  (update_i),
  .fault_i   (fault_i),
  .map_o     (map_o),
  .ftype_o   (ftype_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .unrecov_o (unrecov_o)
);

// File: tb/tb_vsu_fault_mapper.sv
module tb_vsu_fault_mapper;
  localparam int N_SU  = 4;
  localparam int N_SM  = 6 * N_SU;
  localparam int IDX_W = $clog2(N_SM);
  localparam int HALF  = N_SU / 2;
  localparam int MW    = N_SU * 6 * IDX_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic update = 1'b0;
  logic [N_SM-1:0] fault = '0;
  logic [MW-1:0] map_w;
  logic [2*N_SU-1:0] ftype_w;
  logic busy, done, unrecov;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vsu_fault_mapper #(.N_SU(N_SU)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .update_i(update), .fault_i(fault),
    .map_o(map_w), .ftype_o(ftype_w), .busy_o(busy), .done_o(done), .unrecov_o(unrecov)
  );

  function automatic int ident(int i, int j);
    return ((i / HALF) * 3 + j / 2) * N_SU + 2 * (i % HALF) + (j % 2);
  endfunction

  function automatic int entry(int i, int j);
    return int'(map_w[(i*6+j)*IDX_W +: IDX_W]);
  endfunction

  function automatic logic [MW-1:0] ident_map();
    logic [MW-1:0] m;
    for (int i = 0; i < N_SU; i++)
      for (int j = 0; j < 6; j++) m[(i*6+j)*IDX_W +: IDX_W] = IDX_W'(ident(i, j));
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input string act,
                     input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [N_SM-1:0] f, output int lat);
    @(negedge clk); fault = f; update = 1'b1;
    @(posedge clk);
    @(negedge clk); update = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!done && lat < 100);
  endtask

  task automatic verify(input logic [N_SM-1:0] f, input int lat, input logic [MW-1:0] pmap,
                        input logic [2*N_SU-1:0] ptype);
    int af [2];
    int s_exp, tot, nsu;
    bit unrec_exp, perm_ok, one_ok, type_ok;
    bit [N_SM-1:0] seen;
    af[0] = 0; af[1] = 0;
    for (int s = 0; s < N_SM; s++) if (f[s]) af[s / (3 * N_SU)]++;
    unrec_exp = (af[0] > HALF) || (af[1] > HALF);
    chk(unrecov == unrec_exp, "R7", "unrecov flag", $sformatf("%0d", unrecov),
        $sformatf("%0d", unrec_exp));
    if (unrec_exp) begin
      chk(map_w == pmap && ftype_w == ptype, "R7", "outputs held",
          $sformatf("%h/%h", map_w, ftype_w), $sformatf("%h/%h", pmap, ptype));
      return;
    end
    perm_ok = 1'b1; one_ok = 1'b1; type_ok = 1'b1; seen = '0;
    for (int i = 0; i < N_SU; i++) begin
      int c, t;
      c = 0; t = 0;
      for (int j = 0; j < 6; j++) begin
        int s;
        s = entry(i, j);
        if (s >= N_SM || seen[s] || (s / N_SU) % 3 != j / 2 || s / (3 * N_SU) != i / HALF)
          perm_ok = 1'b0;
        else seen[s] = 1'b1;
        if (s < N_SM && f[s]) begin c++; t = j / 2 + 1; end
      end
      if (c > 1) one_ok = 1'b0;
      if (int'(ftype_w[2*i +: 2]) != t) type_ok = 1'b0;
    end
    chk(perm_ok, "R4", "permutation/phase/arm", $sformatf("%h", map_w), "valid layout");
    chk(one_ok, "R3", "single fault per subunit", $sformatf("%h f=%h", map_w, f), "<=1");
    chk(type_ok, "R5", "type codes", $sformatf("%h", ftype_w), "phase of fault");
    tot = 0; nsu = 0;
    for (int i = 0; i < N_SU; i++) begin
      int c;
      c = 0;
      for (int j = 0; j < 6; j++) if (f[ident(i, j)]) c++;
      tot += c;
      if (c > 0) nsu++;
    end
    s_exp = N_SU + tot - nsu;
    chk(lat == s_exp, "R8", "done latency", $sformatf("%0d", lat), $sformatf("%0d", s_exp));
  endtask

  task automatic sweep(input logic [N_SM-1:0] f);
    logic [MW-1:0] pm;
    logic [2*N_SU-1:0] pt;
    int lat;
    pm = map_w; pt = ftype_w;
    run(f, lat);
    verify(f, lat, pm, pt);
  endtask

  task automatic entry_chk(input string req, input int i, input int j, input int e);
    chk(entry(i, j) == e, req, $sformatf("entry su%0d slot%0d", i, j),
        $sformatf("%0d", entry(i, j)), $sformatf("%0d", e));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(map_w == ident_map() && ftype_w == '0, "R1", "reset table",
        $sformatf("%h/%h", map_w, ftype_w), $sformatf("%h/0", ident_map()));
    chk(!busy && !done && !unrecov, "R1", "reset flags",
        $sformatf("%b%b%b", busy, done, unrecov), "000");
    rst_ni = 1'b1;

    // R6: two u-phase faults in subunit 0 go to subunit 1 slot 1
    sweep(N_SM'(1) << 0 | N_SM'(1) << 1);
    entry_chk("R6", 0, 1, 3);
    entry_chk("R6", 1, 1, 1);
    chk(ftype_w == 8'h05, "R6", "both type u", $sformatf("%h", ftype_w), "05");
    // R6: u and v faults in subunit 0 -> subunit 1 takes slot 2
    sweep(N_SM'(1) << 0 | N_SM'(1) << 4);
    entry_chk("R6", 0, 2, 6);
    entry_chk("R6", 1, 2, 4);
    chk(ftype_w == 8'h09, "R6", "type u and v", $sformatf("%h", ftype_w), "09");
    // R6: donor below the scanned subunit
    sweep(N_SM'(1) << 2 | N_SM'(1) << 3);
    entry_chk("R6", 0, 1, 3);
    entry_chk("R6", 1, 1, 1);
    // R2: no faults restores identity
    sweep('0);
    chk(map_w == ident_map() && ftype_w == '0, "R2", "identity restore",
        $sformatf("%h", map_w), $sformatf("%h", ident_map()));

    // R9: strobe while busy ignored
    @(negedge clk); fault = N_SM'(3); update = 1'b1;
    @(posedge clk);
    @(negedge clk); fault = '1; update = 1'b1;
    @(negedge clk); update = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin @(posedge clk); lat++; @(negedge clk); end
    chk(!unrecov && entry(0, 1) == 3 && entry(1, 1) == 1, "R9", "busy strobe ignored",
        $sformatf("u%0d e%0d", unrecov, entry(0, 1)), "u0 e3");
    @(negedge clk);
    chk(!busy, "R9", "no restart", $sformatf("%0d", busy), "0");

    // exhaustive sweeps, each arm alone (R3 R4 R5 R7 R8)
    for (int v = 0; v < 4096; v++) sweep({12'b0, 12'(v)});
    for (int v = 0; v < 4096; v++) sweep({12'(v), 12'b0});
    // mixed arms
    for (int v = 0; v < 64; v++) sweep({6'(v), 6'b0, 6'(v * 5), 6'b0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule